// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor as two outputs: an ordinary interrupt and a critical interrupt. Each line has its own sense (active-high or active-low) and its own capture mode (latched on an active edge or tracking the active level). Each line is also gated by an enable bit and steered to one of the two outputs by a routing bit. All of these settings sit in a small register window on a simple device-control bus. The window starts at a base register number fixed by a parameter.

For the critical path the block also forms a handler address. It takes a programmable base, with its two low bits dropped, and adds 512 times the rank of the winning pending critical line. A direction bit decides whether line 0 or line 31 holds the top rank. Software reads this address from a read-only register. Status is cleared by writing ones to the status register.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The polarity register (offset 3) gives each line its sense: bit value 1 means active-high, and bit value 0 means active-low, so the line is inverted before any further use.
- R2: A line whose trigger bit (offset 4) is 1 sets its status bit one clock after its active level rises, and the bit then holds. Writing 1 to that bit of the status register (offset 0) clears it. It stays clear until the next rising active level, even if the line is held active.
- R3: A line whose trigger bit is 0 has a status bit equal to its active level one clock earlier. A write of 1 to that status bit does not clear it while the line stays active.
- R4: The normal output `irq_norm` is high exactly when some line has status, enable (offset 1) and routing (offset 2) bits equal to 1, 1 and 0.
- R5: The critical output `irq_crit` is high exactly when some line has status, enable and routing bits all equal to 1.
- R6: Offset 5 reads as status AND enable. Writes to offset 5 and to offset 7 change no state.
- R7: With bit 0 of the vector configuration (offset 6) at 0, the vector register (offset 7) reads as (config with bits 1:0 cleared) + 512 × n, where n is the lowest-numbered pending critical line.
- R8: With bit 0 of the vector configuration at 1, the rank is 31 − n, where n is the highest-numbered pending critical line.
- R9: A write to offset 6 stores the written value with bit 1 forced to 0, and the stored value reads back.
- R10: The vector register reads as 0 whenever no critical interrupt is pending.
- R11: While reset is asserted, all configuration, status and vector registers read as 0 and both outputs are low.
- R12: The registers sit at bus numbers BASE_NUM+0 through BASE_NUM+7. Accesses outside that window change nothing and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_IRQ | Raw interrupt request lines |
| cfg_en | input | 1 | Bus access strobe |
| cfg_we | input | 1 | Bus write (1) or read (0) |
| cfg_addr | input | ADDR_W | Bus register number |
| cfg_wdata | input | 32 | Bus write data |
| cfg_rdata | output | 32 | Bus read data, combinational from the address |
| irq_norm | output | 1 | Normal interrupt output |
| irq_crit | output | 1 | Critical interrupt output |

## Verification
The bench targets the difference between latched and tracking lines. A clear-by-write must keep an edge line clear while its input stays high, and it must fail to clear a level line that is still active; swapping the two capture rules would break both checks. The vector corner cases place pending lines at both ends of the range under each direction setting. An inverted scan or a rank that is not mirrored would give a visibly wrong address. Writes to the read-only offsets and to addresses just outside the window are followed by read-backs, so any decode that leaks a write shows up as a changed register.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VIC_DW = 32;
    localparam int VIC_OFF_W = 3;

    typedef enum logic [VIC_OFF_W-1:0] {
        OFF_STS = 3'd0,
        OFF_ENA = 3'd1,
        OFF_CRT = 3'd2,
        OFF_POL = 3'd3,
        OFF_TRG = 3'd4,
        OFF_MSK = 3'd5,
        OFF_VCF = 3'd6,
        OFF_VEC = 3'd7
    } vic_off_e;
endpackage

// File: rtl/vic_in_cond.sv
module vic_in_cond #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] pol,
    output logic [NUM_IRQ-1:0] lvl,
    output logic [NUM_IRQ-1:0] rise
);
    logic [NUM_IRQ-1:0] prev_d, prev_q;

    // Sense adjustment per line: polarity 0 inverts the raw line.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_sense
        assign lvl[g] = pol[g] ? irq_in[g] : ~irq_in[g];
    end

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen #(
    parameter int NUM_IRQ     = 32,
    parameter int STRIDE_LOG2 = 9
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [31:0]        vcfg,
    output logic [31:0]        vec
);
    localparam int POS_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [POS_W-1:0] pos;

    always_comb begin
        pos = '0;
        if (vcfg[0]) begin
            // top rank at the high end: the last hit in an upward scan wins
            for (int i = 0; i < NUM_IRQ; i++)
                if (pend[i]) pos = POS_W'(NUM_IRQ - 1 - i);
        end else begin
            for (int i = NUM_IRQ - 1; i >= 0; i--)
                if (pend[i]) pos = POS_W'(i);
        end
        vec = (|pend) ? ({vcfg[31:2], 2'b00} + (32'(pos) << STRIDE_LOG2)) : 32'd0;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_IRQ  = 32,
    parameter int ADDR_W   = 10,
    parameter int BASE_NUM = 'h0C0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cfg_en,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               irq_norm,
    output logic               irq_crit
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_NUM);

    typedef struct packed {
        logic [NUM_IRQ-1:0] sts;
        logic [NUM_IRQ-1:0] ena;
        logic [NUM_IRQ-1:0] crt;
        logic [NUM_IRQ-1:0] pol;
        logic [NUM_IRQ-1:0] trg;
        logic [31:0]        vcf;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0]    rel;
    logic                 hit, wr, sts_wr;
    vic_off_e             off;
    logic [NUM_IRQ-1:0]   sts_clr, lvl, rise, pend_n, pend_c;
    logic [31:0]          vec;

    vic_in_cond #(.NUM_IRQ(NUM_IRQ)) i_in_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .pol    (r_q.pol),
        .lvl    (lvl),
        .rise   (rise)
    );

    vic_vec_gen #(.NUM_IRQ(NUM_IRQ), .STRIDE_LOG2(9)) i_vec_gen (
        .pend (pend_c),
        .vcfg (r_q.vcf),
        .vec  (vec)
    );

    always_comb begin
        rel     = cfg_addr - BASE_A;
        hit     = (rel[ADDR_W-1:VIC_OFF_W] == '0);
        off     = vic_off_e'(rel[VIC_OFF_W-1:0]);
        wr      = cfg_en && cfg_we && hit;
        sts_wr  = wr && (off == OFF_STS);
        sts_clr = sts_wr ? cfg_wdata[NUM_IRQ-1:0] : '0;

        r_d = r_q;
        if (wr) begin
            case (off)
                OFF_ENA: r_d.ena = cfg_wdata[NUM_IRQ-1:0];
                OFF_CRT: r_d.crt = cfg_wdata[NUM_IRQ-1:0];
                OFF_POL: r_d.pol = cfg_wdata[NUM_IRQ-1:0];
                OFF_TRG: r_d.trg = cfg_wdata[NUM_IRQ-1:0];
                OFF_VCF: r_d.vcf = cfg_wdata & ~32'h2;
                default: ;
            endcase
        end
        // edge lines latch and clear on write-one; level lines track the level
        r_d.sts = (r_q.trg & ((r_q.sts & ~sts_clr) | rise)) | (~r_q.trg & lvl);

        pend_n   = r_q.sts & r_q.ena & ~r_q.crt;
        pend_c   = r_q.sts & r_q.ena & r_q.crt;
        irq_norm = |pend_n;
        irq_crit = |pend_c;

        cfg_rdata = '0;
        if (cfg_en && hit) begin
            case (off)
                OFF_STS: cfg_rdata = 32'(r_q.sts);
                OFF_ENA: cfg_rdata = 32'(r_q.ena);
                OFF_CRT: cfg_rdata = 32'(r_q.crt);
                OFF_POL: cfg_rdata = 32'(r_q.pol);
                OFF_TRG: cfg_rdata = 32'(r_q.trg);
                OFF_MSK: cfg_rdata = 32'(r_q.sts & r_q.ena);
                OFF_VCF: cfg_rdata = r_q.vcf;
                OFF_VEC: cfg_rdata = vec;
                default: cfg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // checker state: marks that one clean edge has passed since reset
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(sts_wr)) |->
        (($past(r_q.sts) & $past(r_q.trg) & ~r_q.sts) == '0));

    // R3
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ((~$past(r_q.trg) & (r_q.sts ^ $past(lvl))) == '0));

    // R9
    vcfg_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vcf[1] == 1'b0);

    // R10
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_crit |-> (vec == 32'd0));

    // R7
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> (vec[8:0] == {r_q.vcf[8:2], 2'b00}));
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
    localparam int NI   = 32;
    localparam int AW   = 10;
    localparam int BASE = 'h0C0;
    localparam logic [2:0] O_STS = 0, O_ENA = 1, O_CRT = 2, O_POL = 3,
                           O_TRG = 4, O_MSK = 5, O_VCF = 6, O_VEC = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_in = '0;
    logic          cfg_en = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          irq_norm, irq_crit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl #(.NUM_IRQ(NI), .ADDR_W(AW), .BASE_NUM(BASE)) i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_norm(irq_norm), .irq_crit(irq_crit)
    );

    typedef struct packed {
        logic [31:0] pol, ena, crt, vcf, irq, msk, vec;
        logic        nrm, cro;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0,        32'h0,        1'b0, 1'b0},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'h10,       32'h10,       32'h0,        1'b1, 1'b0},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h10000,    32'h30,       32'h30,       32'h10800,    1'b0, 1'b1},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h10001,    32'h30,       32'h30,       32'h13400,    1'b0, 1'b1},
        '{32'h0,        32'h1,        32'h0,        32'h0,        32'hFFFFFFFE, 32'h1,        32'h0,        1'b1, 1'b0},
        '{32'hFFFFFFFF, 32'h0000FF00, 32'h0,        32'h0,        32'hFF,       32'h0,        32'h0,        1'b0, 1'b0},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'hABCD0002, 32'h80000001, 32'h80000001, 32'hABCD3E00, 1'b1, 1'b1},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1,        32'hFFFF0003, 32'h1,        32'h1,        32'hFFFF3E00, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_a(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] o, input logic [31:0] d);
        wr_a(AW'(BASE) + AW'(o), d);
    endtask

    task automatic rd_a(input logic [AW-1:0] a, output logic [31:0] d);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] o, output logic [31:0] d);
        rd_a(AW'(BASE) + AW'(o), d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        // R11: reset state, sampled while reset is held
        repeat (3) @(negedge clk);
        chk("R11 norm", 32'(irq_norm), 0);
        chk("R11 crit", 32'(irq_crit), 0);
        rd(O_STS, v); chk("R11 status", v, 0);
        rd(O_ENA, v); chk("R11 enable", v, 0);
        rd(O_VCF, v); chk("R11 vcfg", v, 0);
        rd(O_VEC, v); chk("R11 vector", v, 0);
        @(negedge clk); rst_n = 1'b1;

        // table of level-mode scenarios: R1 R4 R5 R6 R7 R8 R9 R10
        foreach (TBL[k]) begin
            irq_in = TBL[k].irq;
            wr(O_TRG, 32'h0);
            wr(O_POL, TBL[k].pol);
            wr(O_ENA, TBL[k].ena);
            wr(O_CRT, TBL[k].crt);
            wr(O_VCF, TBL[k].vcf);
            repeat (2) @(negedge clk);
            chk($sformatf("R4 norm row%0d", k), 32'(irq_norm), 32'(TBL[k].nrm));
            chk($sformatf("R5 crit row%0d", k), 32'(irq_crit), 32'(TBL[k].cro));
            rd(O_MSK, v); chk($sformatf("R1/R6 masked row%0d", k), v, TBL[k].msk);
            rd(O_VEC, v); chk($sformatf("R7/R8/R10 vector row%0d", k), v, TBL[k].vec);
            rd(O_VCF, v); chk($sformatf("R9 vcfg row%0d", k), v, TBL[k].vcf & ~32'h2);
        end

        // R2: edge capture, hold, clear, no re-set while held high
        irq_in = '0;
        wr(O_POL, 32'hFFFFFFFF); wr(O_ENA, 32'hFFFFFFFF);
        wr(O_CRT, 32'h0); wr(O_VCF, 32'h0); wr(O_TRG, 32'h8);
        wr(O_STS, 32'hFFFFFFFF);
        @(negedge clk);
        chk("R2 idle norm", 32'(irq_norm), 0);
        irq_in[3] = 1'b1; @(negedge clk); irq_in[3] = 1'b0;
        @(negedge clk);
        rd(O_MSK, v); chk("R2 latched", v, 32'h8);
        chk("R2 norm high", 32'(irq_norm), 1);
        repeat (3) @(negedge clk);
        rd(O_MSK, v); chk("R2 held", v, 32'h8);
        wr(O_STS, 32'h8);
        rd(O_MSK, v); chk("R2 cleared", v, 0);
        chk("R2 norm low", 32'(irq_norm), 0);
        irq_in[3] = 1'b1; repeat (2) @(negedge clk);
        rd(O_MSK, v); chk("R2 second edge", v, 32'h8);
        wr(O_STS, 32'h8); repeat (3) @(negedge clk);
        rd(O_MSK, v); chk("R2 clear while held", v, 0);
        irq_in[3] = 1'b0;

        // R3: level line cannot be cleared while still active
        wr(O_TRG, 32'h0);
        irq_in[7] = 1'b1; repeat (2) @(negedge clk);
        rd(O_MSK, v); chk("R3 level set", v, 32'h80);
        wr(O_STS, 32'h80);
        rd(O_MSK, v); chk("R3 clear ignored", v, 32'h80);
        irq_in[7] = 1'b0; repeat (2) @(negedge clk);
        rd(O_MSK, v); chk("R3 follows low", v, 0);

        // R6: read-only offsets ignore writes
        irq_in[7] = 1'b1; repeat (2) @(negedge clk);
        wr(O_MSK, 32'h0); wr(O_VEC, 32'hFFFFFFFF);
        rd(O_STS, v); chk("R6 status kept", v, 32'h80);
        rd(O_ENA, v); chk("R6 enable kept", v, 32'hFFFFFFFF);
        rd(O_VEC, v); chk("R6/R10 vector kept", v, 0);

        // R12: out-of-window accesses
        wr_a(AW'(BASE + 9), 32'h0);
        wr_a(AW'(BASE - 5), 32'h0);
        rd(O_ENA, v); chk("R12 enable unaffected", v, 32'hFFFFFFFF);
        rd(O_POL, v); chk("R12 polarity unaffected", v, 32'hFFFFFFFF);
        rd_a(AW'(BASE + 9), v); chk("R12 read above", v, 0);
        rd_a(AW'(BASE - 1), v); chk("R12 read below", v, 0);

        // R11: reset in mid-run
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R11 mid norm", 32'(irq_norm), 0);
        rd(O_ENA, v); chk("R11 mid enable", v, 0);
        rd(O_STS, v); chk("R11 mid status", v, 0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule